// File: doc/BRIEF.md
# RMII MAC-Side Adapter

This block connects a byte-wide MAC datapath to the two-bit reduced media-independent interface. Everything runs on one 50 MHz reference clock, and all interface pins are launched and captured on its rising edge. On the transmit side, bytes arrive through a valid/ready handshake. Each byte is split into dibits, least significant pair first, and driven on `txd` while `tx_en` is high. Whenever the transmitter is not sending, `txd` is held at 2'b00.

On the receive side, the block watches `crs_dv`, `rxd` and `rx_er`. Bytes are assembled from the first 2'b01 dibit seen in a carrier period. Completed bytes are delivered as single-cycle pulses. The final byte of a frame carries an end marker and a sticky error flag that records any `rx_er` seen while `crs_dv` was high.

A collision signal for an upstream MAC is derived from `tx_en` and `crs_dv`. There is no heartbeat pulse after a transmission.

Top module: `rmii_mac_adapter`

## Requirements
- R1: A synchronous active-high `rst` puts the block in its idle state on the next clock edge: `tx_en`=0, `txd`=2'b00, `col`=0, `m_valid`=0, and `s_ready`=1 once `rst` is released.
- R2: A byte accepted at a clock edge appears on `txd` starting on the next cycle. It takes four consecutive cycles, in the order bits [1:0], [3:2], [5:4], [7:6].
- R3: `s_ready` is high only when the transmitter is idle, or when the final dibit of a byte not marked `s_last` is on `txd`. Bytes offered back to back therefore keep `tx_en` high without a gap for the whole frame.
- R4: `tx_en` falls on the cycle after the final dibit of a byte accepted with `s_last`=1. It also falls there when no byte is offered at a boundary after a non-last byte (underrun).
- R5: `txd` is 2'b00 in every cycle in which `tx_en` is low.
- R6: `col` equals `tx_en` AND `crs_dv`. It never pulses after a transmission while `crs_dv` is low.
- R7: With `crs_dv` high, dibits other than 2'b01 before the first 2'b01 are discarded. That first 2'b01 becomes bits [1:0] of the first byte, and later dibits fill each byte from the low pair upward.
- R8: Each completed byte is output with a one-cycle `m_valid`. The byte completed last before `crs_dv` is sampled low carries `m_last`=1 and is output on the cycle after that sample. Dibits of an incomplete trailing byte are dropped.
- R9: `m_err` is 1 on the `m_last` byte if `rx_er` was high in any cycle of that carrier period in which `crs_dv` was high. `m_err` is 0 on all other output bytes.
- R10: `rx_er` has no effect while `crs_dv` is low. The error flag clears at frame end, so a clean following frame reports `m_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Transmit byte offered |
| s_data | input | BYTE_W | Transmit byte |
| s_last | input | 1 | Offered byte ends the frame |
| s_ready | output | 1 | Transmitter takes the offered byte this cycle |
| tx_en | output | 1 | Transmit enable to the PHY |
| txd | output | 2 | Transmit dibit to the PHY |
| crs_dv | input | 1 | Carrier sense / receive data valid from the PHY |
| rxd | input | 2 | Receive dibit from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| m_valid | output | 1 | Received byte strobe |
| m_data | output | BYTE_W | Received byte |
| m_last | output | 1 | Received byte is the last of its frame |
| m_err | output | 1 | Frame saw a receive error (with m_last) |
| col | output | 1 | Regenerated collision indication |

## Verification
The bench builds the block with the default `BYTE_W` of 8, so one byte takes four dibits. A single table of bytes then reaches every transmit boundary, including frame end, underrun and back-to-back acceptance, within a few dozen cycles. The same table is replayed into the receive pins with leading non-preamble dibits, mid-frame errors, errors outside carrier and trailing partial bytes. A transmit burst with carrier asserted exposes the collision output.

// File: rtl/rmii_mac_adapter.sv
module rmii_mac_adapter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tx_en,
  output logic [1:0]        txd,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  input  logic              rx_er,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              m_err,
  output logic              col
);
  localparam int DIBITS = BYTE_W / 2;
  localparam int CW = (DIBITS > 1) ? $clog2(DIBITS) : 1;
  localparam logic [CW-1:0] LASTD = CW'(DIBITS - 1);

  logic [BYTE_W-3:0] tx_sh;
  logic [CW-1:0]     tx_cnt;
  logic              tx_lastb;

  wire tx_bound = tx_en && (tx_cnt == LASTD);
  assign s_ready = !tx_en || (tx_bound && !tx_lastb);
  wire tx_take = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en    <= 1'b0;
      txd      <= 2'b00;
      tx_sh    <= '0;
      tx_cnt   <= '0;
      tx_lastb <= 1'b0;
    end else if (tx_take) begin
      tx_en    <= 1'b1;
      txd      <= s_data[1:0];
      tx_sh    <= s_data[BYTE_W-1:2];
      tx_cnt   <= '0;
      tx_lastb <= s_last;
    end else if (tx_bound) begin
      tx_en  <= 1'b0;
      txd    <= 2'b00;
      tx_cnt <= '0;
    end else if (tx_en) begin
      txd    <= tx_sh[1:0];
      tx_sh  <= tx_sh >> 2;
      tx_cnt <= tx_cnt + CW'(1);
    end
  end

  assign col = tx_en & crs_dv;

  logic [BYTE_W-3:0] rx_acc;
  logic [BYTE_W-1:0] rx_hold;
  logic [CW-1:0]     rx_cnt;
  logic              rx_asm, rx_have, rx_err;

  wire [BYTE_W-1:0] rx_next = {rxd, rx_acc};
  wire              rx_full = (rx_cnt == LASTD);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_acc  <= '0;
      rx_hold <= '0;
      rx_cnt  <= '0;
      rx_asm  <= 1'b0;
      rx_have <= 1'b0;
      rx_err  <= 1'b0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
      m_err   <= 1'b0;
    end else begin
      m_valid <= 1'b0;
      m_last  <= 1'b0;
      m_err   <= 1'b0;
      if (!crs_dv) begin
        if (rx_asm && rx_have) begin
          m_valid <= 1'b1;
          m_data  <= rx_hold;
          m_last  <= 1'b1;
          m_err   <= rx_err;
        end
        rx_asm  <= 1'b0;
        rx_have <= 1'b0;
        rx_err  <= 1'b0;
        rx_cnt  <= '0;
      end else begin
        if (rx_er) rx_err <= 1'b1;
        if (!rx_asm) begin
          if (rxd == 2'b01) begin
            rx_asm <= 1'b1;
            rx_acc <= rx_next[BYTE_W-1:2];
            rx_cnt <= CW'(1);
          end
        end else begin
          rx_acc <= rx_next[BYTE_W-1:2];
          if (rx_full) begin
            rx_cnt  <= '0;
            rx_hold <= rx_next;
            rx_have <= 1'b1;
            if (rx_have) begin
              m_valid <= 1'b1;
              m_data  <= rx_hold;
            end
          end else begin
            rx_cnt <= rx_cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

module rmii_mac_adapter_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_valid,
  input logic [1:0] s_lo,
  input logic       s_ready,
  input logic       tx_en,
  input logic [1:0] txd,
  input logic       crs_dv,
  input logic       col,
  input logic       m_valid,
  input logic       m_last,
  input logic       m_err
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!tx_en && txd == 2'b00 && !m_valid)); // R1
  AST_FIRST_DIBIT: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && s_valid && s_ready) |=> (tx_en && txd == $past(s_lo))); // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (tx_en && s_valid && s_ready) |=> tx_en); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !tx_en |-> txd == 2'b00); // R5
  AST_NO_SQE: assert property (@(posedge clk) disable iff (rst)
    ($fell(tx_en) && !crs_dv) |-> !col); // R6
  AST_LAST_ON_END: assert property (@(posedge clk) disable iff (rst)
    m_last |-> (m_valid && !$past(crs_dv))); // R8
  AST_ERR_WITH_LAST: assert property (@(posedge clk) disable iff (rst) m_err |-> m_last); // R9
endmodule

bind rmii_mac_adapter rmii_mac_adapter_chk chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_lo(s_data[1:0]), .s_ready(s_ready),
  .tx_en(tx_en), .txd(txd), .crs_dv(crs_dv), .col(col),
  .m_valid(m_valid), .m_last(m_last), .m_err(m_err)
);

// File: tb/rmii_mac_adapter_test.sv
module rmii_mac_adapter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready, tx_en, col, m_valid, m_last, m_err;
  logic [1:0] txd;
  logic       crs_dv = 1'b0, rx_er = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic [7:0] m_data;

  always #4 clk = ~clk;

  rmii_mac_adapter #(.BYTE_W(8)) uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .tx_en(tx_en), .txd(txd), .crs_dv(crs_dv), .rxd(rxd),
    .rx_er(rx_er), .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
    .m_err(m_err), .col(col)
  );

  // {last, byte}
  localparam logic [8:0] VEC [6] = '{9'h0D5, 9'h0A3, 9'h03C, 9'h1E7, 9'h05D, 9'h1F0};

  int checks = 0, fails = 0;
  logic [1:0] cap [64];
  int ncap = 0, nframes = 0, idle_bad = 0, col_bad = 0, col_hi = 0;
  logic prev_en = 1'b0;
  logic [7:0] rd [16];
  logic rl [16], re [16];
  int nr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_en) begin
        if (ncap < 64) cap[ncap] = txd;
        ncap++;
        if (!prev_en) nframes++;
      end else if (txd != 2'b00) idle_bad++;
      if (col !== (tx_en & crs_dv)) col_bad++;
      if (col) col_hi++;
      prev_en = tx_en;
      if (m_valid && nr < 16) begin
        rd[nr] = m_data; rl[nr] = m_last; re[nr] = m_err; nr++;
      end
    end else prev_en = 1'b0;
  end

  task automatic send(input logic [7:0] d, input logic l);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = l;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic rx_send(input int first, input int n, input int lead, input int erpos,
                         input bit eridle, input int extra);
    if (eridle) begin
      repeat (2) begin @(negedge clk); crs_dv = 1'b0; rx_er = 1'b1; rxd = 2'b01; end
    end
    for (int i = 0; i < lead; i++) begin
      @(negedge clk); crs_dv = 1'b1; rxd = 2'b10; rx_er = 1'b0;
    end
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); crs_dv = 1'b1; rxd = VEC[first+b][2*k +: 2]; rx_er = (b*4+k == erpos);
      end
    for (int i = 0; i < extra; i++) begin
      @(negedge clk); crs_dv = 1'b1; rxd = 2'b11; rx_er = 1'b0;
    end
    @(negedge clk); crs_dv = 1'b0; rxd = 2'b00; rx_er = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_expect(input int first, input int n, input bit erx, input string req);
    chk(nr == n, req, nr, n);
    for (int k = 0; k < n && k < nr; k++)
      chk(rd[k] == VEC[first+k][7:0] && rl[k] == (k == n-1) && re[k] == (erx && k == n-1),
          req, {rd[k], 3'b0, rl[k], 3'b0, re[k]},
          {VEC[first+k][7:0], 3'b0, k == n-1, 3'b0, erx && k == n-1});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!tx_en, "R1 tx_en", tx_en, 0);
    chk(txd == 2'b00, "R1 txd", txd, 0);
    chk(!col && !m_valid, "R1 col/m_valid", {col, m_valid}, 0);
    chk(s_ready, "R1 s_ready", s_ready, 1);

    // R2 R3 R4: table walk, two frames back to back within each
    for (int i = 0; i < 6; i++) begin
      send(VEC[i][7:0], VEC[i][8]);
      if (VEC[i][8]) begin @(negedge clk); s_valid = 1'b0; end
    end
    repeat (8) @(negedge clk);
    for (int i = 0; i < 6; i++)
      chk({cap[4*i+3], cap[4*i+2], cap[4*i+1], cap[4*i]} == VEC[i][7:0], "R2 dibit order",
          {cap[4*i+3], cap[4*i+2], cap[4*i+1], cap[4*i]}, VEC[i][7:0]);
    chk(nframes == 2, "R3 contiguous tx_en per frame", nframes, 2);
    chk(ncap == 24, "R4 tx_en length", ncap, 24);

    // R4 underrun
    ncap = 0; nframes = 0;
    send(8'h96, 1'b0);
    @(negedge clk); s_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(ncap == 4 && nframes == 1, "R4 underrun", ncap, 4);
    chk({cap[3], cap[2], cap[1], cap[0]} == 8'h96, "R2 underrun byte",
        {cap[3], cap[2], cap[1], cap[0]}, 8'h96);

    // R6 collision, R7 hunt never leaves on 00
    col_hi = 0; nr = 0;
    @(negedge clk); crs_dv = 1'b1; rxd = 2'b00;
    send(8'h81, 1'b1);
    @(negedge clk); s_valid = 1'b0;
    while (tx_en) @(negedge clk);
    crs_dv = 1'b0;
    repeat (6) @(negedge clk);
    chk(col_hi == 4, "R6 col during overlap", col_hi, 4);
    chk(col_bad == 0, "R6 col mismatch/SQE", col_bad, 0);
    chk(nr == 0, "R7 no assembly without 01", nr, 0);
    chk(idle_bad == 0, "R5 idle txd", idle_bad, 0);

    // R7 R8 R9: clean frame with leading junk dibits
    nr = 0; rx_send(0, 4, 3, -1, 1'b0, 0);
    rx_expect(0, 4, 1'b0, "R7/R8 frame");
    // R9 error mid-frame
    nr = 0; rx_send(4, 2, 0, 5, 1'b0, 0);
    rx_expect(4, 2, 1'b1, "R9 error frame");
    // R10 rx_er with carrier low ignored, flag cleared
    nr = 0; rx_send(4, 2, 1, -1, 1'b1, 0);
    rx_expect(4, 2, 1'b0, "R10 idle error ignored");
    // R8 partial trailing dibits dropped
    nr = 0; rx_send(0, 2, 0, -1, 1'b0, 3);
    rx_expect(0, 2, 1'b0, "R8 partial byte");

    // R1 reset mid-transmission
    send(8'hC3, 1'b0);
    @(negedge clk); s_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!tx_en && txd == 2'b00 && !col, "R1 mid-frame reset", {tx_en, txd}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready, "R1 ready after reset", s_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule